// File: doc/BRIEF.md
# Bus Mode Detect and Debounce

This block decides which kind of transceivers share a differential bus. It takes two comparator flags derived from the bus sense line. One flag says the level is under the single-ended limit. The other says the level is over the high-voltage differential limit. The block turns these flags into one of three bus classes. A class becomes the committed mode only after it has held steady for a long qualification window. That window is counted in prescaled ticks and lasts a few hundred milliseconds at the default parameters.

The committed mode drives three one-hot status outputs. It also drives a terminator enable. The enable is high only in low-voltage differential mode, and only while the active-high disconnect input is low. Both comparator flags pass through a two-stage synchronizer before they are classified. The qualification logic restarts whenever the synchronized class moves to a new value. It abandons the attempt if the class falls back to the mode already committed.

Top module: `bus_mode_detect`

## Requirements
- R1: While reset is high, and at the first clock after it, the committed mode is single-ended. The outputs are then mode_se_o=1, mode_lvd_o=0, mode_hvd_o=0 and term_en_o=0.
- R2: The raw class is high-voltage differential whenever above_hvd_i is 1, whatever below_se_i is. It is single-ended when only below_se_i is 1. It is low-voltage differential when both flags are 0.
- R3: A raw class that differs from the committed mode becomes the committed mode after it has stayed unchanged for exactly QUAL_TICKS*CLKS_PER_TICK clock edges. Before that, the committed mode is unchanged.
- R4: When the raw class changes to a third value while a change is pending, qualification restarts from zero with the new class as candidate.
- R5: When the raw class returns to the committed mode before qualification finishes, the committed mode does not change and the pending count is discarded.
- R6: At every cycle exactly one of mode_se_o, mode_lvd_o, mode_hvd_o is 1.
- R7: term_en_o is 1 exactly when the committed mode is low-voltage differential and disconnect_i is 0.
- R8: disconnect_i has no effect on the committed mode or on the qualification timing.
- R9: Each comparator flag reaches the classifier through two register stages. A change driven before clock edge A1 therefore starts qualification at edge A3, and the mode flips at edge A(3+QUAL_TICKS*CLKS_PER_TICK).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| below_se_i | input | 1 | Comparator flag: sense level under the single-ended limit (asynchronous) |
| above_hvd_i | input | 1 | Comparator flag: sense level over the high-voltage differential limit (asynchronous) |
| disconnect_i | input | 1 | High forces the terminator off |
| mode_se_o | output | 1 | Committed mode is single-ended |
| mode_lvd_o | output | 1 | Committed mode is low-voltage differential |
| mode_hvd_o | output | 1 | Committed mode is high-voltage differential |
| term_en_o | output | 1 | Terminator enable |

## Verification
The assertions assume that the synchronized class is what the qualifier sees. They also assume the prescaler tick is the only event that can move the committed mode. Together these let a mode change be tied to a tick and to the class held one cycle earlier. The stimulus changes the comparator flags and the disconnect input only on the falling clock edge. Each flag level is held for a chosen number of cycles, sometimes shorter and sometimes longer than the qualification window. Both flags high is driven as a legal input, because it must resolve to high-voltage differential. Disconnect toggles during qualification, so its independence from the timing is exercised.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

    typedef enum logic [1:0] {
        BM_SE  = 2'd0,
        BM_LVD = 2'd1,
        BM_HVD = 2'd2
    } bus_mode_e;

    typedef struct packed {
        logic above_hvd;
        logic below_se;
    } sense_flags_t;

    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned FLAG_W      = $bits(sense_flags_t);

    // High-voltage flag wins over the single-ended flag.
    function automatic bus_mode_e classify(input sense_flags_t f);
        if (f.above_hvd)     return BM_HVD;
        else if (f.below_se) return BM_SE;
        else                 return BM_LVD;
    endfunction

    // Bit order {hvd, lvd, se}.
    function automatic logic [2:0] mode_onehot(input bus_mode_e m);
        logic [2:0] v;
        v = 3'b000;
        case (m)
            BM_SE:   v = 3'b001;
            BM_LVD:  v = 3'b010;
            BM_HVD:  v = 3'b100;
            default: v = 3'b001;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/bmd_sync.sv
module bmd_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bmd_tick_gen.sv
module bmd_tick_gen #(
    parameter int unsigned DIV = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt_q;

    assign tick_o = run_i && (pcnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i)        pcnt_q <= '0;
        else if (pcnt_q == LAST)  pcnt_q <= '0;
        else                      pcnt_q <= pcnt_q + 1'b1;
    end

    // R3
    prescale_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (pcnt_q == '0));
endmodule

// File: rtl/bmd_qualifier.sv
module bmd_qualifier
    import bmd_pkg::*;
#(
    parameter int unsigned QUAL_TICKS = 200
) (
    input  logic      clk,
    input  logic      rst,
    input  bus_mode_e raw_i,
    input  logic      tick_i,
    output logic      pending_o,
    output bus_mode_e mode_o
);
    localparam int unsigned CW = (QUAL_TICKS > 1) ? $clog2(QUAL_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUAL_TICKS - 1);

    bus_mode_e     mode_q;
    bus_mode_e     cand_q;
    logic [CW-1:0] cnt_q;
    logic          seen_q;

    assign pending_o = (raw_i != mode_q) && (raw_i == cand_q);
    assign mode_o    = mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= BM_SE;
            cand_q <= BM_SE;
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
            if (raw_i == mode_q) begin
                cand_q <= mode_q;
                cnt_q  <= '0;
            end else if (raw_i != cand_q) begin
                cand_q <= raw_i;
                cnt_q  <= '0;
            end else if (tick_i) begin
                if (cnt_q == LAST) begin
                    mode_q <= cand_q;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R3
    commit_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && (mode_q != $past(mode_q))) |-> $past(tick_i));

    // R2
    commit_matches_raw_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && (mode_q != $past(mode_q))) |-> (mode_q == $past(raw_i)));

    // R5
    abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (raw_i == mode_q) |=> (cnt_q == '0));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
endmodule

// File: rtl/bus_mode_detect.sv
module bus_mode_detect
    import bmd_pkg::*;
#(
    parameter int unsigned CLKS_PER_TICK = 200000,
    parameter int unsigned QUAL_TICKS    = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic below_se_i,
    input  logic above_hvd_i,
    input  logic disconnect_i,
    output logic mode_se_o,
    output logic mode_lvd_o,
    output logic mode_hvd_o,
    output logic term_en_o
);
    sense_flags_t flags_async;
    sense_flags_t flags_sync;
    bus_mode_e    raw_mode;
    bus_mode_e    committed;
    logic         pending;
    logic         tick;
    logic [2:0]   status;

    assign flags_async.above_hvd = above_hvd_i;
    assign flags_async.below_se  = below_se_i;

    bmd_sync #(
        .WIDTH  (FLAG_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (flags_async),
        .q_o (flags_sync)
    );

    assign raw_mode = classify(flags_sync);

    bmd_tick_gen #(
        .DIV (CLKS_PER_TICK)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .run_i  (pending),
        .tick_o (tick)
    );

    bmd_qualifier #(
        .QUAL_TICKS (QUAL_TICKS)
    ) u_qual (
        .clk       (clk),
        .rst       (rst),
        .raw_i     (raw_mode),
        .tick_i    (tick),
        .pending_o (pending),
        .mode_o    (committed)
    );

    assign status     = mode_onehot(committed);
    assign mode_se_o  = status[0];
    assign mode_lvd_o = status[1];
    assign mode_hvd_o = status[2];
    assign term_en_o  = (committed == BM_LVD) && !disconnect_i;

    // R6
    onehot_status_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({mode_hvd_o, mode_lvd_o, mode_se_o}) == 1);

    // R7
    term_off_when_disc_chk: assert property (@(posedge clk) disable iff (rst)
        (disconnect_i || !mode_lvd_o) |-> !term_en_o);
endmodule

// File: tb/bus_mode_detect_tb.sv
module bus_mode_detect_tb;
    localparam int unsigned DIV = 3;
    localparam int unsigned QT  = 4;
    localparam int unsigned QD  = DIV * QT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic below_se = 1'b0;
    logic above_hvd = 1'b0;
    logic disc = 1'b0;
    logic m_se, m_lvd, m_hvd, t_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    bus_mode_detect #(
        .CLKS_PER_TICK (DIV),
        .QUAL_TICKS    (QT)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .below_se_i   (below_se),
        .above_hvd_i  (above_hvd),
        .disconnect_i (disc),
        .mode_se_o    (m_se),
        .mode_lvd_o   (m_lvd),
        .mode_hvd_o   (m_hvd),
        .term_en_o    (t_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: 0=SE 1=LVD 2=HVD
    int mdl_mode, mdl_cand, mdl_n;
    bit q1_se, q1_hv, q2_se, q2_hv;
    bit mdl_valid = 1'b0;

    function automatic int cls(input bit se, input bit hv);
        if (hv) return 2;
        if (se) return 1 - 1;
        return 1;
    endfunction

    function automatic int onehot_of(input int m);
        return 1 << m;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mdl_mode = 0; mdl_cand = 0; mdl_n = 0;
            q1_se = 0; q1_hv = 0; q2_se = 0; q2_hv = 0;
            mdl_valid = 1'b1;
        end else begin
            int raw;
            raw = cls(q2_se, q2_hv);
            if (raw == mdl_mode) begin
                mdl_cand = mdl_mode; mdl_n = 0;
            end else if (raw != mdl_cand) begin
                mdl_cand = raw; mdl_n = 0;
            end else begin
                mdl_n++;
                if (mdl_n == QD) begin
                    mdl_mode = mdl_cand; mdl_n = 0;
                end
            end
            q2_se = q1_se; q2_hv = q1_hv;
            q1_se = below_se; q1_hv = above_hvd;
        end
        #1;
        if (mdl_valid && !done) begin
            chk("R6 mode vs model", {m_hvd, m_lvd, m_se}, onehot_of(mdl_mode));
            chk("R7 term_en vs model", t_en, (mdl_mode == 1 && !disc) ? 1 : 0);
        end
    end

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input bit se, input bit hv);
        below_se = se; above_hvd = hv;
    endtask

    function automatic int cur_mode();
        return {m_hvd, m_lvd, m_se};
    endfunction

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        int lfsr;
        edges(4);
        #1;
        // R1 reset state
        chk("R1 status during reset", cur_mode(), 1);
        chk("R1 term_en during reset", t_en, 0);
        rst = 1'b0;
        edges(1); #1;
        chk("R1 status after reset", cur_mode(), 1);
        chk("R1 term_en after reset", t_en, 0);

        // R2: both flags low qualifies LVD
        edges(QD + 10); #1;
        chk("R2 both low gives LVD", cur_mode(), 2);
        chk("R7 term_en in LVD", t_en, 1);
        disc = 1'b1; #1;
        chk("R7 disconnect forces off", t_en, 0);
        chk("R8 disconnect keeps mode", cur_mode(), 2);
        edges(1); disc = 1'b0;

        // R3/R9 exact timing to HVD
        drive(0, 1);
        edges(2 + QD); #1;
        chk("R3 before window ends", cur_mode(), 2);
        edges(1); #1;
        chk("R9 commit at edge 3+window", cur_mode(), 4);
        chk("R7 term off in HVD", t_en, 0);

        // R5 abort: short LVD excursion
        drive(0, 0);
        edges(QD - 2);
        drive(0, 1);
        edges(3 * QD); #1;
        chk("R5 aborted change leaves HVD", cur_mode(), 4);

        // R4 candidate switch SE -> LVD
        drive(1, 0);
        edges(6);
        drive(0, 0);
        edges(2 + QD); #1;
        chk("R4 restart holds old mode", cur_mode(), 4);
        edges(1); #1;
        chk("R4 new candidate commits", cur_mode(), 2);

        // R2 precedence: both flags high -> HVD
        drive(1, 1);
        edges(3 + QD); #1;
        chk("R2 hvd flag has precedence", cur_mode(), 4);

        // R8 disconnect toggling during qualification
        drive(1, 0);
        for (int i = 0; i < 2 + QD; i++) begin
            disc = ~disc;
            edges(1);
        end
        #1;
        chk("R8 timing unaffected before", cur_mode(), 4);
        edges(1); #1;
        chk("R2 only se flag gives SE", cur_mode(), 1);
        chk("R8 timing unaffected at commit", cur_mode(), 1);
        disc = 1'b0;

        // mixed pattern, model compared each cycle
        lfsr = 32'h1d5a;
        for (int it = 0; it < 300; it++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            drive(lfsr[0], lfsr[1] & lfsr[2]);
            disc = lfsr[5] & lfsr[6];
            edges(1 + (lfsr[11:8] % 4 == 0 ? QD + 4 : lfsr[11:8]));
        end

        // R1 reset in mid-run
        rst = 1'b1;
        edges(2); #1;
        chk("R1 mid-run reset", cur_mode(), 1);
        chk("R1 mid-run reset term", t_en, 0);
        rst = 1'b0;
        edges(2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule